// File: doc/BRIEF.md
# Compare-Match Waveform Timer

This block is an up-counter whose period is set by a programmable wrap value. Two compare channels, A and B, each hold a waveform state bit. When the counter equals a channel's compare value, that bit is held, toggled, cleared or set, according to a 2-bit action field for that channel. Only normal (non-PWM) counting is provided.

Software drives a single write port. Through it, software programs the wrap value, the compare values, the action fields, one-shot force strobes, preset values for the waveform states and the pin enables. It also clears the sticky overflow and compare flags by writing 1 to them.

A newly written action field is staged. The next compare match on that channel applies the new field and makes it the active one. A force strobe applies the active field immediately. A waveform state can be preloaded while its pin is disabled, so the pin comes up at a known level when it is enabled.

Top module: `cmw_timer`

## Requirements
- R1: The counter starts at 0 after reset. It adds 1 on each clock and returns to 0 on the clock after it equals the wrap value (address 0, reset value 255), so the period is wrap+1 cycles.
- R2: Action code 00 leaves the waveform state unchanged on a compare match. The action fields sit at address 3: bits [1:0] for channel A and bits [3:2] for channel B.
- R3: Action code 01 inverts the waveform state on every match of the counter with the channel's compare value. The compare value for A is at address 1 and the one for B is at address 2.
- R4: On a match, action code 10 drives the state to 0 and action code 11 drives it to 1.
- R5: A match applies the most recently written action field and makes it the active field. A force strobe issued before that match still uses the previously active field.
- R6: Writing 1 to address 4 (bit 0 for A, bit 1 for B) applies the channel's active action on the next clock. A force sets no compare flag and does not disturb the count.
- R7: A write to address 5 (bit 0 for A, bit 1 for B) loads the waveform state of every channel whose pin is disabled. For a channel whose pin is enabled, the write is ignored.
- R8: The overflow flag sets when the counter wraps, and a channel's compare flag sets on its match. Both flags stay set until 1 is written to address 7 (bit 0 overflow, bit 1 A, bit 2 B). If a set and a clear fall in the same cycle, the set wins.
- R9: While a channel's enable bit is 0 (address 6, bit 0 for A, bit 1 for B), its pin reads 0, but the internal state keeps updating on matches. The pin shows that state as soon as it is enabled.
- R10: The action fields never change the counting sequence or the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| wave_o | output | 2 | Gated waveform pins, bit 0 = A, bit 1 = B |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 2 | Sticky compare flags, bit 0 = A, bit 1 = B |

## Verification
The assertions check on every cycle the counter step and wrap, and the effect of each action code on a match. They also check the commit of the staged field into the active one, flag setting and stickiness, and that a preset loads the written value. Only the bench scenarios can show the behaviour seen at the pins. This covers a force that uses the old field before a match, a preset that is ignored while the pin is enabled, and internal toggles that appear only once the pin is enabled. It also covers the measured period staying at wrap+1 with actions active, and write-1-to-clear on the flags.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    CM_NONE   = 2'b00,
    CM_TOGGLE = 2'b01,
    CM_CLEAR  = 2'b10,
    CM_SET    = 2'b11
  } cm_mode_e;

  localparam logic [ADDR_W-1:0] ADR_TOP    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP_A  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP_B  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FORCE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_PRESET = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = 3'd7;

  function automatic logic cm_apply(cm_mode_e m, logic cur);
    case (m)
      CM_TOGGLE: return ~cur;
      CM_CLEAR:  return 1'b0;
      CM_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmw_regs.sv
module cmw_regs
  import cmw_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned N_CH  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [CNT_W-1:0]                top_o,
  output logic [N_CH-1:0][CNT_W-1:0]      cmp_o,
  output logic [N_CH-1:0][1:0]            mode_pend_o,
  output logic [N_CH-1:0]                 en_o,
  output logic [N_CH-1:0]                 force_o,
  output logic                            preset_stb_o,
  output logic [N_CH-1:0]                 preset_val_o,
  output logic                            clr_ovf_o,
  output logic [N_CH-1:0]                 clr_cmp_o
);
  logic [CNT_W-1:0]           top_q;
  logic [N_CH-1:0][CNT_W-1:0] cmp_q;
  logic [N_CH-1:0][1:0]       pend_q;
  logic [N_CH-1:0]            en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q  <= '1;
      cmp_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADR_TOP:    top_q    <= wr_data_i;
        ADR_CMP_A:  cmp_q[0] <= wr_data_i;
        ADR_CMP_B:  cmp_q[N_CH-1] <= wr_data_i;
        ADR_MODE:   for (int i = 0; i < N_CH; i++) pend_q[i] <= wr_data_i[2*i +: 2];
        ADR_ENABLE: en_q     <= wr_data_i[N_CH-1:0];
        default: ;
      endcase
    end
  end

  assign top_o        = top_q;
  assign cmp_o        = cmp_q;
  assign mode_pend_o  = pend_q;
  assign en_o         = en_q;
  assign preset_stb_o = wr_en_i && (wr_addr_i == ADR_PRESET);
  assign preset_val_o = wr_data_i[N_CH-1:0];
  assign clr_ovf_o    = wr_en_i && (wr_addr_i == ADR_FLAGS) && wr_data_i[0];

  for (genvar g = 0; g < N_CH; g++) begin : g_strobe
    assign force_o[g]   = wr_en_i && (wr_addr_i == ADR_FORCE) && wr_data_i[g];
    assign clr_cmp_o[g] = wr_en_i && (wr_addr_i == ADR_FLAGS) && wr_data_i[g+1];
  end
endmodule

// File: rtl/cmw_counter.sv
module cmw_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] top_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  // all-ones escape covers a wrap value lowered below the running count
  assign wrap = (cnt_q == top_i) || (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)           ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign ovf_flag_o = ovf_q;

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == top_i) |=> (cnt_q == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != top_i && cnt_q != '1) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == top_i) |=> ovf_q); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_ovf_i) |=> ovf_q); // R8
endmodule

// File: rtl/cmw_channel.sv
module cmw_channel
  import cmw_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       mode_pend_i,
  input  logic             force_i,
  input  logic             preset_stb_i,
  input  logic             preset_val_i,
  input  logic             en_i,
  input  logic             clr_flag_i,
  output logic             wave_o,
  output logic             flag_o
);
  cm_mode_e pend;
  cm_mode_e act_q;
  logic     state_q;
  logic     flag_q;
  logic     match;
  logic     load;

  assign pend  = cm_mode_e'(mode_pend_i);
  assign match = (cnt_i == cmp_i);
  assign load  = preset_stb_i && !en_i;

  // priority: preset > match > force
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      act_q   <= CM_NONE;
      flag_q  <= 1'b0;
    end else begin
      if (load)         state_q <= preset_val_i;
      else if (match)   state_q <= cm_apply(pend, state_q);
      else if (force_i) state_q <= cm_apply(act_q, state_q);
      if (match) act_q <= pend;
      if (match)           flag_q <= 1'b1;
      else if (clr_flag_i) flag_q <= 1'b0;
    end
  end

  assign wave_o = state_q & en_i;
  assign flag_o = flag_q;

  AST_MATCH_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !load && pend == CM_NONE) |=> (state_q == $past(state_q))); // R2
  AST_MATCH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !load && pend == CM_TOGGLE) |=> (state_q != $past(state_q))); // R3
  AST_MATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !load && pend == CM_CLEAR) |=> !state_q); // R4
  AST_MATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !load && pend == CM_SET) |=> state_q); // R4
  AST_STAGE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> (act_q == $past(pend))); // R5
  AST_FORCE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !match && !load && act_q == CM_SET) |=> state_q); // R6
  AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match && !flag_q) |=> !flag_q); // R6
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (state_q == $past(preset_val_i))); // R7
  AST_CMP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag_q); // R8
endmodule

// File: rtl/cmw_timer.sv
module cmw_timer
  import cmw_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned N_CH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_CH-1:0]   wave_o,
  output logic              ovf_flag_o,
  output logic [N_CH-1:0]   cmp_flag_o
);
  logic [CNT_W-1:0]           top;
  logic [N_CH-1:0][CNT_W-1:0] cmp;
  logic [N_CH-1:0][1:0]       mode_pend;
  logic [N_CH-1:0]            en;
  logic [N_CH-1:0]            force_stb;
  logic                       preset_stb;
  logic [N_CH-1:0]            preset_val;
  logic                       clr_ovf;
  logic [N_CH-1:0]            clr_cmp;
  logic [CNT_W-1:0]           cnt;

  cmw_regs #(.CNT_W(CNT_W), .N_CH(N_CH)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .top_o        (top),
    .cmp_o        (cmp),
    .mode_pend_o  (mode_pend),
    .en_o         (en),
    .force_o      (force_stb),
    .preset_stb_o (preset_stb),
    .preset_val_o (preset_val),
    .clr_ovf_o    (clr_ovf),
    .clr_cmp_o    (clr_cmp)
  );

  cmw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .top_i      (top),
    .clr_ovf_i  (clr_ovf),
    .cnt_o      (cnt),
    .ovf_flag_o (ovf_flag_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    cmw_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cnt_i        (cnt),
      .cmp_i        (cmp[g]),
      .mode_pend_i  (mode_pend[g]),
      .force_i      (force_stb[g]),
      .preset_stb_i (preset_stb),
      .preset_val_i (preset_val[g]),
      .en_i         (en[g]),
      .clr_flag_i   (clr_cmp[g]),
      .wave_o       (wave_o[g]),
      .flag_o       (cmp_flag_o[g])
    );
  end

  assign count_o = cnt;
endmodule

// File: tb/tb_cmw_timer.sv
`timescale 1ns/1ps
module tb_cmw_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic [1:0] wave;
  logic       ovf;
  logic [1:0] cflag;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  cmw_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .count_o(count), .wave_o(wave),
    .ovf_flag_o(ovf), .cmp_flag_o(cflag)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, one posedge later
  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(logic [7:0] v);
    while (count != v) @(negedge clk);
  endtask

  task automatic measure_period(string req, int exp);
    int n = 0;
    wait_cnt(8'd0);
    do begin
      @(negedge clk);
      n++;
    end while (count != 8'd0);
    chk(req, n, exp);
  endtask

  task automatic t_reset();
    chk("R1 count after reset", count, 0);
    chk("R9 pins after reset", wave, 0);
    chk("R8 overflow after reset", ovf, 0);
    @(negedge clk);
    chk("R1 first increment", count, 1);
  endtask

  task automatic t_count();
    wr(3'd1, 8'd200);
    wr(3'd2, 8'd200);
    wr(3'd0, 8'd9);
    wait_cnt(8'd9);
    @(negedge clk);
    chk("R1 wrap to zero", count, 0);
    chk("R8 overflow set on wrap", ovf, 1);
    measure_period("R1 period top+1", 10);
    wait_cnt(8'd2);
    wr(3'd7, 8'h07);
    chk("R8 overflow cleared by w1c", ovf, 0);
    chk("R8 compare flags cleared", cflag, 0);
    wait_cnt(8'd9);
    @(negedge clk);
    chk("R8 overflow sets again", ovf, 1);
  endtask

  task automatic t_preset();
    wr(3'd5, 8'h01);
    chk("R9 disabled pin stays low", wave[0], 0);
    wr(3'd6, 8'h01);
    chk("R7 preset level at enable", wave[0], 1);
    wr(3'd5, 8'h00);
    chk("R7 preset ignored when enabled", wave[0], 1);
  endtask

  task automatic t_force();
    logic [7:0] c0;
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h01);
    chk("R5 force uses previous field", wave[0], 1);
    wr(3'd1, 8'd5);
    wait_cnt(8'd5);
    @(negedge clk);
    chk("R3 toggle on match", wave[0], 0);
    chk("R8 compare flag A set", cflag[0], 1);
    wr(3'd1, 8'd200);
    wr(3'd7, 8'h02);
    chk("R8 compare flag A cleared", cflag[0], 0);
    c0 = count;
    wr(3'd4, 8'h01);
    chk("R6 force applies toggle", wave[0], 1);
    chk("R6 force sets no flag", cflag[0], 0);
    chk("R6 force keeps counting", count, (c0 == 8'd9) ? 0 : c0 + 1);
  endtask

  task automatic t_modes();
    wr(3'd6, 8'h03);
    wr(3'd3, 8'h0C);
    wr(3'd4, 8'h02);
    chk("R5 staged set not used by force", wave[1], 0);
    wr(3'd2, 8'd3);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R4 set on match", wave[1], 1);
    wr(3'd3, 8'h08);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R4 clear on match", wave[1], 0);
    wr(3'd6, 8'h01);
    wr(3'd5, 8'h03);
    wr(3'd6, 8'h03);
    wr(3'd3, 8'h00);
    wr(3'd7, 8'h04);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R2 no action on match", wave[1], 1);
    chk("R8 compare flag B set", cflag[1], 1);
    measure_period("R10 period unchanged by modes", 10);
  endtask

  task automatic t_toggle_hidden();
    wr(3'd3, 8'h04);
    wr(3'd6, 8'h01);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R9 pin low while disabled", wave[1], 0);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R9 pin low after second toggle", wave[1], 0);
    wr(3'd6, 8'h03);
    chk("R9 internal state shown on enable", wave[1], 1);
    wait_cnt(8'd3);
    @(negedge clk);
    chk("R3 toggle again", wave[1], 0);
    measure_period("R10 period with toggle active", 10);
  endtask

  initial begin
    #500000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_preset();
    t_force();
    t_modes();
    t_toggle_hidden();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule